// File: doc/BRIEF.md
# Set/Clear Paired Control Register Bank

This block is a bank of 32-bit control words for reset control, clock-stop control and hardware strap settings, sitting on a simple single-cycle word bus. Each control word is reached through two addresses. A write to the first address ORs the write data into the word. A write to the second address, one word higher, clears every bit that is 1 in the write data. Software can therefore raise or drop individual bits without a read-modify-write. The stored words drive output ports directly.

Each of the two strap words also has a protect register two words above its set address. While the protect register holds a non-zero value, both the set alias and the clear alias of that strap word are frozen. A key register at offset 0 opens the bank when it is written with a magic value. In this bank the closed key does not block writes. It only raises an error indication for the write. Three PLL extension words always report lock in bit 31. A few identity words and a pseudo-random word are read-only.

Top module: `setclr_regbank`

## Requirements
- R1: After reset the words read as follows: 0x040 = 0xF7C3FED8, 0x050 = 0xFFFFFFFC, 0x080 = 0xFFFF7F8A, 0x090 = 0xFFF0FFF0, 0x200 = 0x1000405F. The strap words read STRAP_A_INIT and STRAP_B_INIT, the protect and PLL extension words read 0, and key_open equals KEY_INIT. The output ports rst_ctrl_a/b and clk_stop_a/b mirror 0x040/0x050 and 0x080/0x090, and strap_a/b mirror 0x500/0x510.
- R2: A write to 0x040, 0x050, 0x080 or 0x090 ORs the write data into that word. The new value appears on the read port and on the output ports from the cycle after the write.
- R3: A write to 0x044, 0x054, 0x084 or 0x094 clears, in the word at the address 4 below, each bit that is 1 in the write data. Reads of these clear aliases return 0.
- R4: Strap words sit at 0x500 and 0x510, their clear aliases at 0x504 and 0x514, and their protect words at 0x508 and 0x518. The protect words are plain read/write words. While a protect word is non-zero, writes to both aliases of its strap word are ignored. While it is zero, those aliases set and clear bits as in R2 and R3.
- R5: 0x200, 0x204, 0x224 and 0x244 are plain read/write words. A read of 0x204, 0x224 or 0x244 returns the stored value with bit 31 forced to 1.
- R6: 0x004, 0x014, 0x5B0 and 0x5B4 read REV_ID, REV2_ID, CHIP_ID_LO and CHIP_ID_HI. Writes to them are ignored.
- R7: 0x540 reads a 32-bit pseudo-random word that starts at RNG_SEED. After each read it steps to {v[30:0], v[31]^v[21]^v[1]^v[0]}. Writes to 0x540 are ignored.
- R8: A write to 0x000 sets the key flag to 1 if the data equals KEY_MAGIC, and to 0 otherwise. A read of 0x000 returns the flag in bit 0, and key_open shows the flag.
- R9: lock_err is 1 in the same cycle as a valid write to any in-window offset other than 0 while the key flag is 0. The write still takes effect. lock_err is 0 at all other times.
- R10: Accesses with bus_addr at or above 0x1000, or with bus_addr[1:0] non-zero, read 0, change nothing and never raise lock_err. Unmapped aligned offsets inside the window read 0 and store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle; 0 when no read |
| lock_err | output | 1 | Write performed while key flag is 0 |
| key_open | output | 1 | Key flag |
| rst_ctrl_a | output | 32 | Reset control word 0x040 |
| rst_ctrl_b | output | 32 | Reset control word 0x050 |
| clk_stop_a | output | 32 | Clock-stop word 0x080 |
| clk_stop_b | output | 32 | Clock-stop word 0x090 |
| strap_a | output | 32 | Strap word 0x500 |
| strap_b | output | 32 | Strap word 0x510 |

## Verification
Directed sequences drive all-ones and single-pattern data through the set and clear aliases, which separates OR, clear and overwrite behaviour. They also toggle each protect word between zero and non-zero around strap writes, which shows whether the guard covers both aliases. Random data at random mapped, unmapped, misaligned and out-of-window addresses is checked against a bench model after every access. Random data reveals bits that a fixed pattern would hide, and the mixed addresses catch decode aliasing. Key writes with the magic value and with other values alternate with locked writes, which separates a lock that flags from a lock that blocks.

// File: rtl/setclr_pkg.sv
package setclr_pkg;
  localparam int DW    = 32;
  localparam int OFS_W = 12;
  localparam int N_CTL = 4;
  localparam int N_STR = 2;
  localparam int N_EXT = 3;

  typedef logic [DW-1:0]    word_t;
  typedef logic [OFS_W-1:0] ofs_t;

  localparam ofs_t CLR_STEP  = 12'h004;
  localparam ofs_t PROT_STEP = 12'h008;

  localparam ofs_t CTL_SET_OFS [N_CTL] = '{12'h040, 12'h050, 12'h080, 12'h090};
  localparam word_t CTL_RST    [N_CTL] = '{32'hF7C3FED8, 32'hFFFFFFFC,
                                           32'hFFFF7F8A, 32'hFFF0FFF0};
  localparam ofs_t STR_SET_OFS [N_STR] = '{12'h500, 12'h510};
  localparam ofs_t EXT_OFS     [N_EXT] = '{12'h204, 12'h224, 12'h244};

  localparam ofs_t  OFS_KEY   = 12'h000;
  localparam ofs_t  OFS_REV   = 12'h004;
  localparam ofs_t  OFS_REV2  = 12'h014;
  localparam ofs_t  OFS_PLL   = 12'h200;
  localparam word_t PLL_RST   = 32'h1000405F;
  localparam ofs_t  OFS_RNG   = 12'h540;
  localparam ofs_t  OFS_ID_LO = 12'h5B0;
  localparam ofs_t  OFS_ID_HI = 12'h5B4;
endpackage

// File: rtl/setclr_word.sv
module setclr_word
  import setclr_pkg::*;
#(
  parameter word_t RST = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_en,
  input  logic  clr_en,
  input  logic  guard,
  input  word_t wdata,
  output word_t q
);
  word_t q_d;
  logic  set_ok;
  logic  clr_ok;

  always_comb begin
    set_ok = set_en & ~guard;
    clr_ok = clr_en & ~guard;
    q_d    = q;
    if (set_ok) q_d = q | wdata;
    else if (clr_ok) q_d = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else if (set_ok | clr_ok) q <= q_d;
  end

  AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !guard) |=> ((q & $past(wdata)) == $past(wdata))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !guard) |=> ((q & $past(wdata)) == '0)); // R3
  AST_GUARD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (guard && (set_en || clr_en)) |=> $stable(q)); // R4
endmodule

// File: rtl/setclr_plain.sv
module setclr_plain
  import setclr_pkg::*;
#(
  parameter word_t RST = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  word_t wdata,
  output word_t q
);
  word_t q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else if (we) q <= q_d;
  end
endmodule

// File: rtl/setclr_lfsr.sv
module setclr_lfsr
  import setclr_pkg::*;
#(
  parameter word_t SEED = 32'h1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  output word_t q
);
  word_t q_d;

  always_comb begin
    q_d = {q[DW-2:0], q[31] ^ q[21] ^ q[1] ^ q[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else if (step) q <= q_d;
  end
endmodule

// File: rtl/setclr_regbank.sv
module setclr_regbank
  import setclr_pkg::*;
#(
  parameter int    ADDR_W       = 16,
  parameter word_t KEY_MAGIC    = 32'hC0DE5A17,
  parameter logic  KEY_INIT     = 1'b0,
  parameter word_t STRAP_A_INIT = 32'h00000000,
  parameter word_t STRAP_B_INIT = 32'h00000000,
  parameter word_t REV_ID       = 32'h05000303,
  parameter word_t REV2_ID      = 32'h05000303,
  parameter word_t CHIP_ID_LO   = 32'h1234ABCD,
  parameter word_t CHIP_ID_HI   = 32'h88884444,
  parameter word_t RNG_SEED     = 32'h2545F491
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              lock_err,
  output logic              key_open,
  output logic [31:0]       rst_ctrl_a,
  output logic [31:0]       rst_ctrl_b,
  output logic [31:0]       clk_stop_a,
  output logic [31:0]       clk_stop_b,
  output logic [31:0]       strap_a,
  output logic [31:0]       strap_b
);
  localparam word_t LOCK_BIT = word_t'(1) << (DW - 1);

  // reset: asynchronous assert, synchronous release
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  // decode
  logic in_win, aligned, wr, rd;
  ofs_t ofs;
  always_comb begin
    in_win  = (bus_addr[ADDR_W-1:OFS_W] == '0);
    aligned = (bus_addr[1:0] == 2'b00);
    ofs     = bus_addr[OFS_W-1:0];
    wr      = bus_sel & bus_wr & in_win & aligned;
    rd      = bus_sel & ~bus_wr & in_win & aligned;
  end

  // key flag
  logic key_q, key_d, key_we;
  always_comb begin
    key_we = wr & (ofs == OFS_KEY);
    key_d  = key_q;
    if (key_we) key_d = (bus_wdata == KEY_MAGIC);
  end
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) key_q <= KEY_INIT;
    else if (key_we) key_q <= key_d;
  end
  assign key_open = key_q;
  assign lock_err = wr & (ofs != OFS_KEY) & ~key_q;

  // set/clear control words
  word_t ctl_q [N_CTL];
  for (genvar g = 0; g < N_CTL; g++) begin : g_ctl
    setclr_word #(.RST(CTL_RST[g])) u_word (
      .clk   (clk),
      .rst_n (rs_n),
      .set_en(wr & (ofs == CTL_SET_OFS[g])),
      .clr_en(wr & (ofs == CTL_SET_OFS[g] + CLR_STEP)),
      .guard (1'b0),
      .wdata (bus_wdata),
      .q     (ctl_q[g])
    );
  end

  // guarded strap words and their protect words
  word_t str_q  [N_STR];
  word_t prot_q [N_STR];
  for (genvar g = 0; g < N_STR; g++) begin : g_str
    localparam word_t SRST = (g == 0) ? STRAP_A_INIT : STRAP_B_INIT;
    setclr_plain #(.RST('0)) u_prot (
      .clk  (clk),
      .rst_n(rs_n),
      .we   (wr & (ofs == STR_SET_OFS[g] + PROT_STEP)),
      .wdata(bus_wdata),
      .q    (prot_q[g])
    );
    setclr_word #(.RST(SRST)) u_word (
      .clk   (clk),
      .rst_n (rs_n),
      .set_en(wr & (ofs == STR_SET_OFS[g])),
      .clr_en(wr & (ofs == STR_SET_OFS[g] + CLR_STEP)),
      .guard (prot_q[g] != '0),
      .wdata (bus_wdata),
      .q     (str_q[g])
    );
  end

  // PLL words
  word_t pll_q;
  setclr_plain #(.RST(PLL_RST)) u_pll (
    .clk  (clk),
    .rst_n(rs_n),
    .we   (wr & (ofs == OFS_PLL)),
    .wdata(bus_wdata),
    .q    (pll_q)
  );
  word_t ext_q [N_EXT];
  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    setclr_plain #(.RST('0)) u_ext (
      .clk  (clk),
      .rst_n(rs_n),
      .we   (wr & (ofs == EXT_OFS[g])),
      .wdata(bus_wdata),
      .q    (ext_q[g])
    );
  end

  // random word
  word_t rng_q;
  setclr_lfsr #(.SEED(RNG_SEED)) u_rng (
    .clk  (clk),
    .rst_n(rs_n),
    .step (rd & (ofs == OFS_RNG)),
    .q    (rng_q)
  );

  // read mux
  word_t rd_mux;
  logic  ext_hit;
  always_comb begin
    rd_mux  = '0;
    ext_hit = 1'b0;
    if (ofs == OFS_KEY)   rd_mux = {{(DW-1){1'b0}}, key_q};
    if (ofs == OFS_REV)   rd_mux = REV_ID;
    if (ofs == OFS_REV2)  rd_mux = REV2_ID;
    if (ofs == OFS_PLL)   rd_mux = pll_q;
    if (ofs == OFS_RNG)   rd_mux = rng_q;
    if (ofs == OFS_ID_LO) rd_mux = CHIP_ID_LO;
    if (ofs == OFS_ID_HI) rd_mux = CHIP_ID_HI;
    for (int i = 0; i < N_CTL; i++) begin
      if (ofs == CTL_SET_OFS[i]) rd_mux = ctl_q[i];
    end
    for (int i = 0; i < N_STR; i++) begin
      if (ofs == STR_SET_OFS[i])             rd_mux = str_q[i];
      if (ofs == STR_SET_OFS[i] + PROT_STEP) rd_mux = prot_q[i];
    end
    for (int i = 0; i < N_EXT; i++) begin
      if (ofs == EXT_OFS[i]) begin
        rd_mux  = ext_q[i] | LOCK_BIT;
        ext_hit = 1'b1;
      end
    end
  end
  assign bus_rdata = rd ? rd_mux : '0;

  assign rst_ctrl_a = ctl_q[0];
  assign rst_ctrl_b = ctl_q[1];
  assign clk_stop_a = ctl_q[2];
  assign clk_stop_b = ctl_q[3];
  assign strap_a    = str_q[0];
  assign strap_b    = str_q[1];

  AST_PLL_LOCK_BIT: assert property (@(posedge clk) disable iff (!rs_n)
    (rd && ext_hit) |-> bus_rdata[31]); // R5
  AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rs_n)
    (bus_sel && (!in_win || !aligned)) |-> (bus_rdata == '0 && !lock_err)); // R10
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rs_n)
    (wr && ofs == OFS_KEY && bus_wdata == KEY_MAGIC) |=> key_open); // R8
  AST_RNG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rs_n)
    (wr && ofs == OFS_RNG) |=> $stable(rng_q)); // R7
endmodule

// File: tb/setclr_regbank_tb.sv
module setclr_regbank_tb;
  localparam logic [31:0] MAGIC = 32'h5EC0_0DE5;
  localparam logic [31:0] SA0   = 32'h0000_1234;
  localparam logic [31:0] SB0   = 32'hA500_0081;
  localparam logic [31:0] REV   = 32'h0301_0000;
  localparam logic [31:0] REV2  = 32'h0302_0001;
  localparam logic [31:0] IDL   = 32'h1357_9BDF;
  localparam logic [31:0] IDH   = 32'h2468_ACE0;
  localparam logic [31:0] SEED  = 32'h0BAD_F00D;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rst_ctrl_a, rst_ctrl_b, clk_stop_a, clk_stop_b, strap_a, strap_b;
  logic lock_err, key_open;

  always #10 clk = ~clk;

  setclr_regbank #(
    .ADDR_W(16), .KEY_MAGIC(MAGIC), .KEY_INIT(1'b0),
    .STRAP_A_INIT(SA0), .STRAP_B_INIT(SB0), .REV_ID(REV), .REV2_ID(REV2),
    .CHIP_ID_LO(IDL), .CHIP_ID_HI(IDH), .RNG_SEED(SEED)
  ) u_dut (.*);

  int n_run = 0, n_fail = 0;

  logic [31:0] m_ctl [4];
  logic [31:0] m_str [2];
  logic [31:0] m_prot [2];
  logic [31:0] m_ext [3];
  logic [31:0] m_pll, m_rng;
  logic        m_key;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lfsr_next(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  function automatic bit valid_ofs(input logic [15:0] a);
    return (a[15:12] == 4'h0) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [15:0] a);
    if (!valid_ofs(a)) return '0;
    case (a[11:0])
      12'h000: return {31'b0, m_key};
      12'h004: return REV;
      12'h014: return REV2;
      12'h040: return m_ctl[0];
      12'h050: return m_ctl[1];
      12'h080: return m_ctl[2];
      12'h090: return m_ctl[3];
      12'h200: return m_pll;
      12'h204: return m_ext[0] | 32'h8000_0000;
      12'h224: return m_ext[1] | 32'h8000_0000;
      12'h244: return m_ext[2] | 32'h8000_0000;
      12'h500: return m_str[0];
      12'h510: return m_str[1];
      12'h508: return m_prot[0];
      12'h518: return m_prot[1];
      12'h540: return m_rng;
      12'h5B0: return IDL;
      12'h5B4: return IDH;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    if (!valid_ofs(a)) return "R10";
    case (a[11:0])
      12'h000: return "R8";
      12'h004, 12'h014, 12'h5B0, 12'h5B4: return "R6";
      12'h040, 12'h050, 12'h080, 12'h090: return "R2";
      12'h044, 12'h054, 12'h084, 12'h094: return "R3";
      12'h500, 12'h504, 12'h508, 12'h510, 12'h514, 12'h518: return "R4";
      12'h200, 12'h204, 12'h224, 12'h244: return "R5";
      12'h540: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic mdl_wr(input logic [15:0] a, input logic [31:0] d);
    if (!valid_ofs(a)) return;
    case (a[11:0])
      12'h000: m_key = (d == MAGIC);
      12'h040: m_ctl[0] |= d;
      12'h050: m_ctl[1] |= d;
      12'h080: m_ctl[2] |= d;
      12'h090: m_ctl[3] |= d;
      12'h044: m_ctl[0] &= ~d;
      12'h054: m_ctl[1] &= ~d;
      12'h084: m_ctl[2] &= ~d;
      12'h094: m_ctl[3] &= ~d;
      12'h500: if (m_prot[0] == 0) m_str[0] |= d;
      12'h504: if (m_prot[0] == 0) m_str[0] &= ~d;
      12'h510: if (m_prot[1] == 0) m_str[1] |= d;
      12'h514: if (m_prot[1] == 0) m_str[1] &= ~d;
      12'h508: m_prot[0] = d;
      12'h518: m_prot[1] = d;
      12'h200: m_pll = d;
      12'h204: m_ext[0] = d;
      12'h224: m_ext[1] = d;
      12'h244: m_ext[2] = d;
      default: ;
    endcase
  endtask

  task automatic chk_ports(input string tag);
    chk(rst_ctrl_a, m_ctl[0], tag);
    chk(rst_ctrl_b, m_ctl[1], tag);
    chk(clk_stop_a, m_ctl[2], tag);
    chk(clk_stop_b, m_ctl[3], tag);
    chk(strap_a, m_str[0], tag);
    chk(strap_b, m_str[1], tag);
    chk({31'b0, key_open}, {31'b0, m_key}, "R8");
  endtask

  task automatic bus_op(input bit w, input logic [15:0] a, input logic [31:0] d);
    bit exp_err;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    exp_err = w && valid_ofs(a) && (a[11:0] != 12'h000) && !m_key;
    #5;
    if (!w) chk(bus_rdata, exp_rd(a), tag_of(a));
    chk({31'b0, lock_err}, {31'b0, exp_err}, "R9");
    @(posedge clk);
    if (w) mdl_wr(a, d);
    else if (valid_ofs(a) && a[11:0] == 12'h540) m_rng = lfsr_next(m_rng);
    #2;
    bus_sel = 1'b0;
    chk_ports(w ? tag_of(a) : "R1");
  endtask

  localparam int NA = 28;
  logic [15:0] addrs [NA] = '{16'h000, 16'h004, 16'h014, 16'h040, 16'h044, 16'h050,
    16'h054, 16'h080, 16'h084, 16'h090, 16'h094, 16'h200, 16'h204, 16'h224, 16'h244,
    16'h500, 16'h504, 16'h508, 16'h510, 16'h514, 16'h518, 16'h540, 16'h5B0, 16'h5B4,
    16'h300, 16'h1040, 16'hF500, 16'h0042};

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_ctl = '{32'hF7C3FED8, 32'hFFFFFFFC, 32'hFFFF7F8A, 32'hFFF0FFF0};
    m_str = '{SA0, SB0};
    m_prot = '{32'h0, 32'h0};
    m_ext = '{32'h0, 32'h0, 32'h0};
    m_pll = 32'h1000405F; m_rng = SEED; m_key = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    // R1 reset state
    chk_ports("R1");
    for (int i = 0; i < NA; i++) bus_op(1'b0, addrs[i], '0);

    // R2 / R3 directed, locked: writes land and flag R9
    bus_op(1'b1, 16'h044, 32'hFFFF_FFFF);
    bus_op(1'b0, 16'h040, '0);
    bus_op(1'b1, 16'h040, 32'h0000_00A5);
    bus_op(1'b1, 16'h040, 32'h0000_5A00);
    bus_op(1'b0, 16'h040, '0);
    bus_op(1'b1, 16'h094, 32'h0F0F_0F0F);
    bus_op(1'b0, 16'h094, '0);
    // R8 key
    bus_op(1'b1, 16'h000, MAGIC);
    bus_op(1'b0, 16'h000, '0);
    bus_op(1'b1, 16'h080, 32'h0000_0075);
    bus_op(1'b1, 16'h000, MAGIC ^ 32'h1);
    bus_op(1'b1, 16'h084, 32'hFFFF_0000);
    // R4 protect
    bus_op(1'b1, 16'h508, 32'h1);
    bus_op(1'b1, 16'h500, 32'hFFFF_FFFF);
    bus_op(1'b1, 16'h504, 32'hFFFF_FFFF);
    bus_op(1'b0, 16'h500, '0);
    bus_op(1'b1, 16'h508, 32'h0);
    bus_op(1'b1, 16'h504, 32'h0000_1200);
    bus_op(1'b1, 16'h518, 32'h8000_0000);
    bus_op(1'b1, 16'h510, 32'h0000_FF00);
    bus_op(1'b0, 16'h510, '0);
    // R5 / R6 / R7 / R10
    bus_op(1'b1, 16'h224, 32'h0000_0001);
    bus_op(1'b0, 16'h224, '0);
    bus_op(1'b1, 16'h5B0, 32'h0);
    bus_op(1'b0, 16'h5B0, '0);
    bus_op(1'b0, 16'h540, '0);
    bus_op(1'b1, 16'h540, 32'h0);
    bus_op(1'b0, 16'h540, '0);
    bus_op(1'b1, 16'h1040, 32'hFFFF_FFFF);
    bus_op(1'b1, 16'h0042, 32'hFFFF_FFFF);
    bus_op(1'b0, 16'h040, '0);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] a;
      logic [31:0] d;
      int k;
      k = $urandom_range(NA - 1);
      a = addrs[k];
      d = $urandom();
      if ((a[11:0] == 12'h508 || a[11:0] == 12'h518) && ($urandom_range(1) == 0)) d = 0;
      if (a[11:0] == 12'h000 && ($urandom_range(1) == 0)) d = MAGIC;
      bus_op($urandom_range(1) == 1, a, d);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule